// File: doc/BRIEF.md
# Mixed-Width Instruction Unpacker

This block sits between the fetch stage and the decode stage of a three-stage core. The core's instruction stream mixes 16-bit and 32-bit instructions. Its program memory is separate and read-only, and it delivers one aligned 32-bit word per access. The unpacker accepts those words together with their word addresses and hands decode one instruction per cycle, along with the address of that instruction's first halfword.

A halfword whose three top bits are all ones opens a 32-bit instruction, except when its next two bits are zero. That exception is the short unconditional branch, which is a 16-bit instruction. A 32-bit instruction that begins in the lower half of a word is issued straight from that word. One that begins in the upper half is parked in a one-halfword holding register until the next word arrives. The two halves are then issued together. Two 16-bit instructions in one word are issued in turn, lower half first.

Decode can stall the unpacker with a ready signal, and the unpacker stalls fetch in the same way. A branch redirect flushes all held state. Along with the flush comes a flag saying whether the redirect target is the upper halfword of its word. If it is, the lower half of the first word fetched afterwards is dropped.

Top module: `halfword_unpacker`

## Requirements
- R1: After reset and before any word is accepted, `dec_valid` is 0 and `fw_ready` is 1.
- R2: A word that holds two 16-bit instructions issues its bits [15:0] and then its bits [31:16], in consecutive cycles when decode is ready.
- R3: A halfword whose bits [15:13] are 111 and whose bits [12:11] are not 00 is the first half of a 32-bit instruction, and `dec_is32` is 1 when that instruction issues.
- R4: A halfword with bits [15:11] equal to 11100 issues as a 16-bit instruction.
- R5: A 32-bit instruction is issued in one cycle with its first halfword in `dec_instr[31:16]` and its second in `dec_instr[15:0]`. A 16-bit instruction appears in `dec_instr[15:0]` with `dec_instr[31:16]` zero.
- R6: A 32-bit instruction that starts in bits [31:16] of one word is completed with bits [15:0] of the next word accepted, and it is issued with PC equal to the first word's address plus 2.
- R7: `dec_pc` is the byte address of the first halfword. Between back-to-back issues it advances by 2 after a 16-bit instruction and by 4 after a 32-bit one.
- R8: While `dec_valid` is 1 and `dec_ready` is 0, the issued instruction and PC hold unchanged and no instruction is lost.
- R9: `fw_ready` is 1, outside a flush, exactly when one of two things is true. Either no halfword of the current word remains after this cycle's issue, or the only halfword held is an unissued first half of a 32-bit instruction.
- R10: A cycle with `flush` at 1 drops every held halfword, issues nothing and accepts no word. In the next cycle `dec_valid` is 0 and `fw_ready` is 1.
- R11: If `redir_half` is 1 during a flush, bits [15:0] of the next accepted word are discarded and issue starts at its bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_valid | input | 1 | A fetch word is offered |
| fw_ready | output | 1 | The unpacker takes the offered word this cycle |
| fw_waddr | input | AW-2 | Word address of the offered word |
| fw_data | input | 32 | Offered word; bits [15:0] are the lower-address halfword |
| flush | input | 1 | Redirect: discard all held state |
| redir_half | input | 1 | With flush: the redirect target is the upper halfword of its word |
| dec_valid | output | 1 | An instruction is presented to decode |
| dec_ready | input | 1 | Decode accepts the presented instruction |
| dec_instr | output | 32 | Instruction bits, laid out as in R5 |
| dec_is32 | output | 1 | The presented instruction is 32 bits wide |
| dec_pc | output | AW | Byte address of the instruction's first halfword |

## Verification
Decode outputs and `fw_ready` follow from the held state and this cycle's inputs without delay. A word accepted at one clock edge can be issued in the cycle after that edge. A flush takes effect at the next edge. The bench drives its inputs just after the falling edge, and a short delay later it compares all outputs against a queue-based model of the halfword stream. It then advances that model by what the coming rising edge will do. As a result, every expectation is due in the same cycle it is compared in, with no extra latency. A straddling instruction shows its one-cycle wait as a `dec_valid` low cycle, because the model holds only one halfword at that point.

// File: rtl/halfword_unpacker.sv
module halfword_unpacker #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fw_valid,
  output logic          fw_ready,
  input  logic [AW-3:0] fw_waddr,
  input  logic [31:0]   fw_data,
  input  logic          flush,
  input  logic          redir_half,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic [31:0]   dec_instr,
  output logic          dec_is32,
  output logic [AW-1:0] dec_pc
);

  logic [31:0]   w_data;
  logic [AW-3:0] w_addr;
  logic          lo_v, hi_v;
  logic          p_v;
  logic [15:0]   p_hw;
  logic [AW-2:0] p_hpc;
  logic          skip;

  logic          iss_v, take_lo, take_hi, park, fire;
  logic          lo_left, hi_left;

  wire [15:0] lo_h = w_data[15:0];
  wire [15:0] hi_h = w_data[31:16];

  function automatic logic opens_long(input logic [15:0] h);
    return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
  endfunction

  always_comb begin
    iss_v     = 1'b0;
    dec_instr = '0;
    dec_is32  = 1'b0;
    dec_pc    = '0;
    take_lo   = 1'b0;
    take_hi   = 1'b0;
    park      = 1'b0;
    if (p_v) begin
      if (lo_v) begin
        iss_v     = 1'b1;
        dec_instr = {p_hw, lo_h};
        dec_is32  = 1'b1;
        dec_pc    = {p_hpc, 1'b0};
        take_lo   = 1'b1;
      end
    end else if (lo_v) begin
      iss_v   = 1'b1;
      dec_pc  = {w_addr, 2'b00};
      take_lo = 1'b1;
      if (opens_long(lo_h)) begin
        dec_instr = {lo_h, hi_h};
        dec_is32  = 1'b1;
        take_hi   = 1'b1;
      end else begin
        dec_instr = {16'h0000, lo_h};
      end
    end else if (hi_v) begin
      if (opens_long(hi_h)) begin
        park = 1'b1;
      end else begin
        iss_v     = 1'b1;
        dec_instr = {16'h0000, hi_h};
        dec_pc    = {w_addr, 2'b10};
        take_hi   = 1'b1;
      end
    end
  end

  assign dec_valid = iss_v & ~flush;
  assign fire      = dec_valid & dec_ready;
  assign lo_left   = lo_v & ~(fire & take_lo);
  assign hi_left   = hi_v & ~((fire & take_hi) | park);
  assign fw_ready  = ~flush & ~lo_left & ~hi_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_data <= '0;
      w_addr <= '0;
      lo_v   <= 1'b0;
      hi_v   <= 1'b0;
      p_v    <= 1'b0;
      p_hw   <= '0;
      p_hpc  <= '0;
      skip   <= 1'b0;
    end else if (flush) begin
      lo_v <= 1'b0;
      hi_v <= 1'b0;
      p_v  <= 1'b0;
      skip <= redir_half;
    end else begin
      if (park) begin
        p_v   <= 1'b1;
        p_hw  <= hi_h;
        p_hpc <= {w_addr, 1'b1};
      end else if (fire && p_v) begin
        p_v <= 1'b0;
      end
      if (fw_valid && fw_ready) begin
        w_data <= fw_data;
        w_addr <= fw_waddr;
        lo_v   <= ~skip;
        hi_v   <= 1'b1;
        skip   <= 1'b0;
      end else begin
        lo_v <= lo_left;
        hi_v <= hi_left;
      end
    end
  end

endmodule

module halfword_unpacker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          fw_ready,
  input logic          dec_valid,
  input logic          dec_ready,
  input logic [31:0]   dec_instr,
  input logic          dec_is32,
  input logic [AW-1:0] dec_pc
);

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready && !flush |=> flush || (dec_valid && $stable(dec_instr) && $stable(dec_pc) && $stable(dec_is32))); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !dec_valid && (fw_ready || flush)); // R10

  AST_BRANCH_IS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_is32 |-> dec_instr[31:27] != 5'b11100 && dec_instr[31:29] == 3'b111); // R4

  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_is32 |-> dec_instr[31:16] == 16'h0000); // R5

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_ready && !flush |=> !dec_valid || flush ||
      dec_pc == $past(dec_pc) + ($past(dec_is32) ? AW'(4) : AW'(2))); // R7

  AST_PC_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !dec_pc[0]); // R7

endmodule

bind halfword_unpacker halfword_unpacker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fw_ready(fw_ready),
  .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_instr(dec_instr),
  .dec_is32(dec_is32), .dec_pc(dec_pc)
);

// File: tb/halfword_unpacker_tb.sv
module halfword_unpacker_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fw_valid = 1'b0;
  logic          fw_ready;
  logic [AW-3:0] fw_waddr = '0;
  logic [31:0]   fw_data = '0;
  logic          flush = 1'b0;
  logic          redir_half = 1'b0;
  logic          dec_valid;
  logic          dec_ready = 1'b0;
  logic [31:0]   dec_instr;
  logic          dec_is32;
  logic [AW-1:0] dec_pc;

  always #4 clk = ~clk;

  halfword_unpacker #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_ready(fw_ready),
    .fw_waddr(fw_waddr), .fw_data(fw_data), .flush(flush), .redir_half(redir_half),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_instr(dec_instr),
    .dec_is32(dec_is32), .dec_pc(dec_pc)
  );

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  int branch_seen = 0;
  int straddle_seen = 0;
  string tag = "R1";

  logic [15:0]   prog[256];
  logic [15:0]   mq[$];
  logic [AW-1:0] mpc[$];
  bit            mskip = 1'b0;
  logic [AW-3:0] fp = '0;

  function automatic bit long_start(input logic [15:0] h);
    return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit rdy, input bit fv, input bit fl, input bit rh);
    bit e_valid, e_ready, e_32;
    logic [31:0] e_instr;
    logic [AW-1:0] e_pc;
    int sz, used;
    @(negedge clk);
    dec_ready  = rdy;
    fw_valid   = fv;
    flush      = fl;
    redir_half = rh;
    fw_waddr   = fp;
    fw_data    = {prog[(2*int'(fp)+1) % 256], prog[(2*int'(fp)) % 256]};
    #1;
    sz = mq.size();
    e_valid = 0; e_32 = 0; e_instr = '0; e_pc = '0; used = 0;
    if (!fl && sz > 0) begin
      if (!long_start(mq[0])) begin
        e_valid = 1; e_instr = {16'h0, mq[0]}; e_pc = mpc[0]; used = 1;
      end else if (sz >= 2) begin
        e_valid = 1; e_32 = 1; e_instr = {mq[0], mq[1]}; e_pc = mpc[0]; used = 2;
      end
    end
    if (!(e_valid && rdy)) used = 0;
    e_ready = !fl && ((sz - used) == 0 || (sz == 1 && long_start(mq[0])));
    check(dec_valid === e_valid, tag, "dec_valid", 64'(dec_valid), 64'(e_valid));
    check(fw_ready === e_ready, "R9", "fw_ready", 64'(fw_ready), 64'(e_ready));
    if (e_valid && dec_valid) begin
      check(dec_instr === e_instr, e_32 ? "R3/R5" : "R4/R5", "dec_instr", 64'(dec_instr), 64'(e_instr));
      check(dec_is32 === e_32, "R3", "dec_is32", 64'(dec_is32), 64'(e_32));
      check(dec_pc === e_pc, e_pc[1] && e_32 ? "R6" : "R7", "dec_pc", 64'(dec_pc), 64'(e_pc));
      if (rdy && !e_32 && e_instr[15:11] == 5'b11100) branch_seen++;
      if (rdy && e_32 && e_pc[1]) straddle_seen++;
    end
    if (fl) begin
      mq.delete(); mpc.delete();
      mskip = rh;
    end else begin
      for (int i = 0; i < used; i++) begin
        void'(mq.pop_front()); void'(mpc.pop_front());
      end
      if (fv && e_ready) begin
        if (!mskip) begin
          mq.push_back(fw_data[15:0]); mpc.push_back({fp, 2'b00});
        end
        mq.push_back(fw_data[31:16]); mpc.push_back({fp, 2'b10});
        mskip = 0;
        fp = fp + 1'b1;
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    x = 32'h1234_5678;
    for (int k = 0; k < 256; k++) begin
      x = x * 32'd1103515245 + 32'd12345;
      prog[k] = x[30:15];
      if (k % 3 == 0) prog[k][15:13] = 3'b111;
    end
    prog[0] = 16'h2101; prog[1] = 16'h4608;
    prog[2] = 16'hE7FD; prog[3] = 16'hF000;
    prog[4] = 16'hF8C0; prog[5] = 16'h3001;
    prog[6] = 16'hE92D; prog[7] = 16'h4FF0;
    prog[8] = 16'hF7FF; prog[9] = 16'hFFFE;
    prog[10] = 16'hBF00; prog[11] = 16'hE800;
    prog[12] = 16'h0000; prog[13] = 16'hE000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(dec_valid === 1'b0, "R1", "reset dec_valid", 64'(dec_valid), 64'(0));
    check(fw_ready === 1'b1, "R1", "reset fw_ready", 64'(fw_ready), 64'(1));

    tag = "R2/R3/R4/R5/R6";
    for (int c = 0; c < 40; c++) step(1, 1, 0, 0);
    check(branch_seen > 0, "R4", "short branches issued", 64'(branch_seen), 64'(1));
    check(straddle_seen > 0, "R6", "straddling issues", 64'(straddle_seen), 64'(1));

    tag = "R8";
    for (int c = 0; c < 200; c++) step(1'($urandom % 2), 1, 0, 0);

    tag = "R9";
    for (int c = 0; c < 200; c++) step(1'($urandom % 2), 1'($urandom % 2), 0, 0);

    tag = "R10";
    for (int c = 0; c < 300; c++) begin
      if ($urandom % 16 == 0) begin
        step(1'($urandom % 2), 1, 1, 0);
        fp = AW'($urandom % 128);
      end else step(1'($urandom % 2), 1'($urandom % 4 != 0), 0, 0);
    end

    tag = "R11";
    for (int c = 0; c < 300; c++) begin
      if ($urandom % 12 == 0) begin
        step(1'($urandom % 2), 1, 1, 1);
        fp = AW'($urandom % 128);
      end else step(1'($urandom % 2), 1'($urandom % 4 != 0), 0, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule